// File: doc/BRIEF.md
# NRZI Line Codec with Bit Stuffing

This block is the bit-level layer of a USB-style serial link. On the transmit side it takes one data bit at a time over a valid/ready handshake. Whenever the accepted bits hold a long run of ones, it slips in an extra zero. Each bit that goes out is turned into a line level using NRZI: a zero flips the level and a one leaves it alone. The level is driven on a complementary pair. Because stuffing guarantees transitions, the far end can recover timing from the line.

The receive side does the reverse. It takes a sampled line level and finds each bit by comparing that level with the one before it. It deletes the zero that follows a full run of ones. If that bit turns out to be a one, it flags a stuffing violation instead.

Both sides move one bit per enabled clock cycle. A transmit bit strobe and a receive bit strobe let a single system clock serve several line rates. Packet framing, sync, end-of-packet signalling and CRC are handled elsewhere.

Top module: `nrzi_stuff_link`

## Requirements
- R1: After reset, `line_p` is 1 and `line_n` is 0. This is the idle level J. `rx_valid` and `rx_stuff_err` are 0.
- R2: In every cycle, `line_n` is the complement of `line_p`.
- R3: A bit slot is a cycle with `bit_en` high. In a slot that sends a bit, `line_p` toggles on the following edge when the bit is 0 and holds when the bit is 1.
- R4: Once `RUN_LEN` (default 6) consecutive ones have been accepted, the next bit slot sends a stuffed 0. `tx_ready` is low in that slot, and only in that slot, so no input bit is lost or repeated.
- R5: The ones-run count returns to zero after any zero is sent, stuffed zeros included, and after any idle slot. A run broken by a zero therefore needs a fresh `RUN_LEN` ones before the next stuffed zero.
- R6: An idle slot is a bit slot with `tx_valid` low and no stuffed zero pending. In an idle slot, `line_p` is driven to J (1) and no bit is consumed.
- R7: In a cycle with `bit_en` low, `tx_ready` is 0, the line holds its level and no bit is consumed.
- R8: When `rx_active` is low, the receiver's previous-level reference is set to J and its run count is cleared. In a cycle with `rx_en` and `rx_active` both high, the decoded bit is 1 if `rx_line` equals the previous level and 0 otherwise. The decoded bit appears on `rx_data`, with a one-cycle `rx_valid` pulse, on the next cycle.
- R9: After `RUN_LEN` consecutive decoded ones, the receiver consumes the next sampled bit without raising `rx_valid`.
- R10: If that consumed bit is a 1, `rx_stuff_err` pulses for exactly one cycle and `rx_valid` stays low. The run count then restarts from zero.
- R11: In a cycle with `rx_en` low, the receiver raises neither `rx_valid` nor `rx_stuff_err`, and it keeps its previous-level reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit bit-slot strobe |
| tx_valid | input | 1 | A transmit bit is offered |
| tx_data | input | 1 | Offered transmit bit |
| tx_ready | output | 1 | Offered bit is taken in this cycle |
| line_p | output | 1 | Positive line level |
| line_n | output | 1 | Negative line level, complement of line_p |
| rx_en | input | 1 | Receive bit-slot strobe |
| rx_active | input | 1 | Receive stream is in progress; low restarts the decoder |
| rx_line | input | 1 | Sampled receive line level |
| rx_valid | output | 1 | One-cycle pulse: decoded bit on rx_data |
| rx_data | output | 1 | Decoded, unstuffed receive bit |
| rx_stuff_err | output | 1 | One-cycle pulse: stuffing violation |

## Verification
The transmitter is driven with several kinds of input. An all-zeros stream shows that every bit produces a transition. A run of seven ones shows exactly where the single stuffed zero lands and the one-cycle ready stall that goes with it. Five ones, a zero and then six ones shows the run count being cleared by a data zero. A long run of ones checks that stuffing repeats every six ones, and that a stuffed zero also clears the count. Gaps with the strobe low, and slots with no valid data, separate a held line from a return to J.

The receiver is fed level sequences that test three things: plain decoding, the silent removal of a correct stuffed zero, and the error pulse when a one arrives in the stuffing position. Gaps with the receive strobe low confirm that the previous-level reference is kept across them.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;
  // Idle (J) line level; encoding starts from here.
  localparam logic J_LEVEL = 1'b1;

  // What the transmitter puts on the line in a given cycle.
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,  // no bit slot: keep level
    SLOT_IDLE  = 2'd1,  // bit slot, nothing to send: go to J
    SLOT_DATA  = 2'd2,  // bit slot carrying an accepted data bit
    SLOT_STUFF = 2'd3   // bit slot carrying an inserted zero
  } slot_kind_e;
endpackage

// File: rtl/tx_stuff_ctrl.sv
module tx_stuff_ctrl
  import line_codec_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       tx_valid,
  input  logic       tx_data,
  output logic       tx_ready,
  output slot_kind_e slot_kind,
  output logic       slot_bit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_q, run_d;
  logic          stuff_due;

  assign stuff_due = (run_q == RUN_MAX);
  assign tx_ready  = bit_en && !stuff_due;

  always_comb begin
    run_d     = run_q;
    slot_kind = SLOT_HOLD;
    slot_bit  = 1'b1;
    if (bit_en) begin
      if (stuff_due) begin
        slot_kind = SLOT_STUFF;
        slot_bit  = 1'b0;
        run_d     = '0;
      end else if (tx_valid) begin
        slot_kind = SLOT_DATA;
        slot_bit  = tx_data;
        run_d     = tx_data ? run_q + CW'(1) : '0;
      end else begin
        slot_kind = SLOT_IDLE;
        run_d     = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/nrzi_line_drv.sv
module nrzi_line_drv
  import line_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slot_kind_e slot_kind,
  input  logic       slot_bit,
  output logic       line_p,
  output logic       line_n
);
  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    case (slot_kind)
      SLOT_DATA, SLOT_STUFF: if (!slot_bit) level_d = ~level_q;
      SLOT_IDLE:             level_d = J_LEVEL;
      default:               level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= J_LEVEL;
    else        level_q <= level_d;
  end

  assign line_p = level_q;
  assign line_n = ~level_q;
endmodule

// File: rtl/rx_unstuff.sv
module rx_unstuff
  import line_codec_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_active,
  input  logic rx_line,
  output logic rx_valid,
  output logic rx_data,
  output logic rx_stuff_err
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_q, run_d;
  logic          prev_q, prev_d;
  logic          valid_d, data_d, err_d;
  logic          dec_bit;

  assign dec_bit = (rx_line == prev_q);

  always_comb begin
    run_d   = run_q;
    prev_d  = prev_q;
    valid_d = 1'b0;
    data_d  = 1'b0;
    err_d   = 1'b0;
    if (!rx_active) begin
      run_d  = '0;
      prev_d = J_LEVEL;
    end else if (rx_en) begin
      prev_d = rx_line;
      if (run_q == RUN_MAX) begin
        err_d = dec_bit;
        run_d = '0;
      end else begin
        valid_d = 1'b1;
        data_d  = dec_bit;
        run_d   = dec_bit ? run_q + CW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= '0;
      prev_q       <= J_LEVEL;
      rx_valid     <= 1'b0;
      rx_data      <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else begin
      run_q        <= run_d;
      prev_q       <= prev_d;
      rx_valid     <= valid_d;
      rx_data      <= data_d;
      rx_stuff_err <= err_d;
    end
  end
endmodule

// File: rtl/nrzi_stuff_link.sv
module nrzi_stuff_link
  import line_codec_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic line_p,
  output logic line_n,
  input  logic rx_en,
  input  logic rx_active,
  input  logic rx_line,
  output logic rx_valid,
  output logic rx_data,
  output logic rx_stuff_err
);
  slot_kind_e slot_kind;
  logic       slot_bit;

  tx_stuff_ctrl #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .slot_kind(slot_kind), .slot_bit(slot_bit)
  );

  nrzi_line_drv u_drv (
    .clk(clk), .rst_n(rst_n), .slot_kind(slot_kind), .slot_bit(slot_bit),
    .line_p(line_p), .line_n(line_n)
  );

  rx_unstuff #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_active(rx_active),
    .rx_line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_stuff_err(rx_stuff_err)
  );
endmodule

// File: rtl/nrzi_stuff_link_checker.sv
module nrzi_stuff_link_checker #(
  parameter int RUN_LEN = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic tx_valid,
  input logic tx_data,
  input logic tx_ready,
  input logic line_p,
  input logic line_n,
  input logic rx_valid,
  input logic rx_stuff_err
);
  localparam int CW = $clog2(RUN_LEN + 1);

  // Ones-run length rebuilt from the handshake alone.
  logic [CW-1:0] ones_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_seen <= '0;
    else if (bit_en) begin
      if (tx_valid && tx_ready) ones_seen <= tx_data ? ones_seen + CW'(1) : '0;
      else                      ones_seen <= '0;
    end
  end

  assert_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_n == ~line_p);

  assert_zero_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && tx_valid && tx_ready && !tx_data) |=> (line_p != $past(line_p)));

  assert_stall_at_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ones_seen == CW'(RUN_LEN)) |-> !tx_ready);

  assert_stall_only_at_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_ready) |-> (ones_seen == CW'(RUN_LEN)));

  assert_no_slot_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !tx_ready);

  assert_no_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_p));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |=> !rx_stuff_err);

  assert_err_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_valid);
endmodule

bind nrzi_stuff_link nrzi_stuff_link_checker #(.RUN_LEN(RUN_LEN)) u_checker (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .line_p(line_p), .line_n(line_n),
  .rx_valid(rx_valid), .rx_stuff_err(rx_stuff_err)
);

// File: tb/tb_nrzi_stuff_link.sv
module tb_nrzi_stuff_link;
  localparam int RUN = 6;

  logic clk, rst_n;
  logic bit_en, tx_valid, tx_data, tx_ready, line_p, line_n;
  logic rx_en, rx_active, rx_line, rx_valid, rx_data, rx_stuff_err;

  int checks = 0;
  int errors = 0;

  // bench model of the transmit line
  logic m_line;
  int   m_run;
  int   stall_cnt;

  nrzi_stuff_link #(.RUN_LEN(RUN)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .line_p(line_p), .line_n(line_n),
    .rx_en(rx_en), .rx_active(rx_active), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_stuff_err(rx_stuff_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One transmit cycle: drive, check ready, then check line after the edge.
  task automatic tx_cycle(input logic en, input logic v, input logic d, output logic took);
    logic exp_ready;
    @(negedge clk);
    bit_en = en; tx_valid = v; tx_data = d;
    #1;
    exp_ready = en && (m_run != RUN);
    if (en && m_run == RUN) check("R4 stall on stuffed slot", tx_ready, exp_ready);
    else if (!en)           check("R7 ready low without slot", tx_ready, exp_ready);
    else                    check("R5 ready in normal slot", tx_ready, exp_ready);
    took = tx_ready && v;
    if (en && !tx_ready) stall_cnt++;
    if (en) begin
      if (m_run == RUN) begin m_line = ~m_line; m_run = 0; end
      else if (v) begin
        if (!d) begin m_line = ~m_line; m_run = 0; end
        else m_run = m_run + 1;
      end else begin m_line = 1'b1; m_run = 0; end
    end
    @(posedge clk); #1;
    check("R3 line level", line_p, m_line);
    check("R2 complement", line_n, ~m_line);
  endtask

  task automatic send_stream(input logic [63:0] bits, input int n);
    int idx = 0;
    logic took;
    while (idx < n) begin
      tx_cycle(1'b1, 1'b1, bits[idx], took);
      if (took) idx++;
    end
  endtask

  task automatic rx_push(input logic en, input logic act, input logic lvl,
                         input logic ev, input logic ed, input logic ee, input string req);
    @(negedge clk);
    rx_en = en; rx_active = act; rx_line = lvl;
    @(posedge clk); #1;
    check(req, rx_valid, ev);
    if (ev) check(req, rx_data, ed);
    check(req, rx_stuff_err, ee);
  endtask

  task automatic t_reset;
    check("R1 line_p idle", line_p, 1'b1);
    check("R1 line_n idle", line_n, 1'b0);
    check("R1 rx_valid", rx_valid, 1'b0);
    check("R1 rx_stuff_err", rx_stuff_err, 1'b0);
  endtask

  task automatic t_zeros;  // R3
    send_stream(64'h0, 5);
  endtask

  task automatic t_seven_ones;  // R4
    logic took;
    tx_cycle(1'b1, 1'b0, 1'b0, took);  // idle slot, R6
    stall_cnt = 0;
    send_stream(64'h7F, 7);
    check("R4 exactly one stall", 1'(stall_cnt == 1), 1'b1);
  endtask

  task automatic t_broken_run;  // R5: 5 ones, 0, 6 ones -> one stall
    logic took;
    tx_cycle(1'b1, 1'b0, 1'b0, took);
    stall_cnt = 0;
    send_stream(64'b1111110_11111, 12);
    tx_cycle(1'b1, 1'b1, 1'b1, took);  // pending stuff slot
    check("R5 stall count after broken run", 1'(stall_cnt == 1), 1'b1);
    check("R4 nothing taken in stuff slot", took, 1'b0);
  endtask

  task automatic t_long_ones;  // R5: stuffed zero clears count
    logic took;
    tx_cycle(1'b1, 1'b0, 1'b0, took);
    stall_cnt = 0;
    send_stream({52'h0, 12'hFFF}, 12);
    tx_cycle(1'b1, 1'b0, 1'b0, took);
    check("R5 two stalls over twelve ones", 1'(stall_cnt == 2), 1'b1);
  endtask

  task automatic t_gaps;  // R6, R7
    logic took;
    send_stream(64'h0, 1);  // line now differs from J? model tracks it
    tx_cycle(1'b0, 1'b1, 1'b0, took);
    check("R7 nothing taken", took, 1'b0);
    tx_cycle(1'b0, 1'b1, 1'b0, took);
    tx_cycle(1'b1, 1'b0, 1'b0, took);
    check("R6 idle goes to J", line_p, 1'b1);
    send_stream(64'h0, 1);
    tx_cycle(1'b1, 1'b0, 1'b0, took);
    check("R6 idle from K to J", line_p, 1'b1);
  endtask

  task automatic t_rx_decode;  // R8: bits 0,1,0,0 from J
    rx_push(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 restart");
    rx_push(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 decode 0");
    rx_push(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 decode 1");
    rx_push(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 decode 0");
    rx_push(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 decode 0");
  endtask

  task automatic t_rx_strip;  // R9
    rx_push(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 restart");
    for (int i = 0; i < RUN; i++)
      rx_push(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9 run of ones");
    rx_push(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 stuffed zero dropped");
    rx_push(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 next bit emitted");
  endtask

  task automatic t_rx_error;  // R10
    rx_push(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 restart");
    for (int i = 0; i < RUN; i++)
      rx_push(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10 run of ones");
    rx_push(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10 violation flagged");
    rx_push(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 pulse ends, count cleared");
  endtask

  task automatic t_rx_gap;  // R11: previous level 0 kept across gap
    rx_push(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 no output when disabled");
    rx_push(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11 reference kept");
    rx_push(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 no output when disabled");
    rx_push(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R11 reference kept");
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; tx_valid = 1'b0; tx_data = 1'b0;
    rx_en = 1'b0; rx_active = 1'b0; rx_line = 1'b1;
    m_line = 1'b1; m_run = 0; stall_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zeros();
    t_seven_ones();
    t_broken_run();
    t_long_ones();
    t_gaps();
    t_rx_decode();
    t_rx_strip();
    t_rx_error();
    t_rx_gap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule